// File: doc/BRIEF.md
# Encoder Position Counter with Marker-Aligned Reload

This block keeps the shaft position of an incremental encoder. An upstream decoder supplies a one-cycle count strobe for each quadrature edge. With each strobe it also gives the direction, the channel that moved and the polarity of that edge. The counter steps up or down once per strobe. It wraps between zero and a programmable maximum count, so one revolution maps onto the range 0 to `max_count`.

When zero reload is enabled, the block watches the filtered zero-marker level. Moving forward, a rising marker edge arms a reload; moving in reverse, a falling marker edge arms it. The reload takes effect on a later strobe: it loads zero when moving forward and `max_count` when moving in reverse. The strobe that performs the first reload fixes the reload edge: its channel and its polarity, stored in forward terms. After that, a forward reload waits for that same edge, and a reverse reload waits for the same channel with the opposite polarity. This keeps the index position free of missing or spurious counts.

Zero reload has no effect while the frequency/direction input mode is active. Clearing the enable, or entering that mode, drops both the armed marker and the stored reload edge. The next enabled period therefore learns a new reload edge.

Top module: `enc_pos_counter`

## Requirements
- R1: After reset, `count` is 0. Each cycle with `step` high changes `count` by +1 when `step_up` is 1 and by −1 when `step_up` is 0. In a cycle with `step` low, `count` holds its value.
- R2: An up step taken at `count == max_count` gives 0, unless a reload applies.
- R3: A down step taken at `count == 0` gives `max_count`, unless a reload applies.
- R4: With reload enabled and `step_up` = 1, a rising edge of `marker` arms a reload. The next qualifying strobe then sets `count` to 0.
- R5: With reload enabled and `step_up` = 0, a falling edge of `marker` arms a reload. The next qualifying strobe then sets `count` to `max_count`. A rising marker edge does not arm a reload in reverse.
- R6: A strobe in the same cycle as the marker edge counts normally. The reload applies only on a later strobe.
- R7: The strobe that performs the first reload stores its channel (`step_on_b`: 1 = B, 0 = A) and its polarity (`step_rise`: 1 = rising). Later forward reloads occur only on a strobe with that same channel and polarity. Other strobes count normally, and the reload stays armed.
- R8: In reverse, a reload occurs only on the stored channel with the opposite polarity.
- R9: While `fd_mode` is 1, `zero_en` is ignored and the marker never reloads the counter.
- R10: When `zero_en` is low or `fd_mode` is high for a cycle, the armed reload and the stored edge are cleared. The next reload then learns a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Count strobe, one cycle per quadrature edge |
| step_up | input | 1 | Direction: 1 forward (count up), 0 reverse |
| step_on_b | input | 1 | Channel of the strobed edge: 1 = B, 0 = A |
| step_rise | input | 1 | Polarity of the strobed edge: 1 = rising |
| marker | input | 1 | Filtered zero-marker level |
| zero_en | input | 1 | Enable for marker reload |
| fd_mode | input | 1 | Frequency/direction mode active; disables reload |
| max_count | input | W | Highest count value |
| count | output | W | Position count |

## Verification
`count` changes at the first clock edge that sees `step` high. The bench raises `step` on a falling edge, lowers it on the next falling edge, and reads `count` at that point, which is half a cycle after the update. A marker edge is registered at the clock edge after the marker input changes. The marker tasks therefore wait one full cycle before the next strobe, except in the same-cycle case, where marker and strobe change together on purpose. Each result is read one cycle after its own strobe, so a reload that arrives late or early shows up as a wrong value at that sample.

// File: rtl/enc_pos_counter.sv
module enc_pos_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         step_up,
  input  logic         step_on_b,
  input  logic         step_rise,
  input  logic         marker,
  input  logic         zero_en,
  input  logic         fd_mode,
  input  logic [W-1:0] max_count,
  output logic [W-1:0] count
);

  logic marker_q, armed, aligned, al_b, al_rise;

  wire en_eff   = zero_en & ~fd_mode;
  wire mk_seen  = step_up ? (marker & ~marker_q) : (~marker & marker_q);
  wire want_rise = step_up ? al_rise : ~al_rise;
  wire edge_ok  = ~aligned | ((step_on_b == al_b) & (step_rise == want_rise));
  wire reload   = step & en_eff & armed & edge_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (reload) begin
      count <= step_up ? '0 : max_count;
    end else if (step) begin
      if (step_up) count <= (count == max_count) ? '0 : count + W'(1);
      else         count <= (count == '0) ? max_count : count - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      marker_q <= 1'b0;
      armed    <= 1'b0;
      aligned  <= 1'b0;
      al_b     <= 1'b0;
      al_rise  <= 1'b0;
    end else begin
      marker_q <= marker;
      if (!en_eff) begin
        armed   <= 1'b0;
        aligned <= 1'b0;
      end else begin
        armed <= mk_seen | (armed & ~reload);
        if (reload && !aligned) begin
          aligned <= 1'b1;
          al_b    <= step_on_b;
          al_rise <= step_up ? step_rise : ~step_rise;
        end
      end
    end
  end

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));

  assert_wrap_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_up && !armed && count == max_count) |=> count == '0);

  assert_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_up && !armed && count == '0) |=> count == $past(max_count));

  assert_fwd_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_up && armed && aligned && zero_en && !fd_mode &&
     step_on_b == al_b && step_rise == al_rise) |=> count == '0);

  assert_fd_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fd_mode |=> !armed && !aligned);

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_en |=> !armed && !aligned);

endmodule

// File: tb/test_enc_pos_counter.sv
module test_enc_pos_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, step_up = 1'b1, step_on_b = 1'b0, step_rise = 1'b1;
  logic marker = 1'b0, zero_en = 1'b0, fd_mode = 1'b0;
  logic [W-1:0] max_count = W'(9);
  logic [W-1:0] count;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_pos_counter #(.W(W)) i_enc_pos_counter (
    .clk(clk), .rst_n(rst_n), .step(step), .step_up(step_up),
    .step_on_b(step_on_b), .step_rise(step_rise), .marker(marker),
    .zero_en(zero_en), .fd_mode(fd_mode), .max_count(max_count), .count(count)
  );

  task automatic chk(input string req, input logic [W-1:0] exp);
    checks++;
    if (count !== exp) begin
      failures++;
      $display("FAIL %s count=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic do_reset(input logic en);
    @(negedge clk);
    rst_n = 1'b0; step = 1'b0; marker = 1'b0; fd_mode = 1'b0;
    step_up = 1'b1; zero_en = en; max_count = W'(9);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input logic up, input logic onb, input logic rise);
    @(negedge clk);
    step = 1'b1; step_up = up; step_on_b = onb; step_rise = rise;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic set_marker(input logic up, input logic v);
    @(negedge clk);
    step_up = up; marker = v;
    @(negedge clk);
  endtask

  task automatic t_count;
    do_reset(1'b0);
    chk("R1 reset", W'(0));
    repeat (3) pulse(1'b1, 1'b0, 1'b1);
    chk("R1 up", W'(3));
    pulse(1'b0, 1'b1, 1'b0);
    chk("R1 down", W'(2));
    repeat (4) @(negedge clk);
    chk("R1 idle", W'(2));
  endtask

  task automatic t_wrap;
    do_reset(1'b0);
    repeat (9) pulse(1'b1, 1'b0, 1'b1);
    chk("R2 at max", W'(9));
    pulse(1'b1, 1'b0, 1'b1);
    chk("R2 wrap up", W'(0));
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3 wrap down", W'(9));
  endtask

  task automatic t_fwd;
    do_reset(1'b1);
    repeat (3) pulse(1'b1, 1'b0, 1'b1);
    set_marker(1'b1, 1'b1);
    pulse(1'b1, 1'b1, 1'b1);
    chk("R4 forward reload", W'(0));
    set_marker(1'b1, 1'b0);
    pulse(1'b1, 1'b0, 1'b1);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R4 no rearm on falling", W'(2));
    set_marker(1'b1, 1'b1);
    pulse(1'b1, 1'b0, 1'b1);
    chk("R7 A rise ignored", W'(3));
    pulse(1'b1, 1'b0, 1'b0);
    chk("R7 A fall ignored", W'(4));
    pulse(1'b1, 1'b1, 1'b1);
    chk("R7 latched B rise", W'(0));
  endtask

  task automatic t_same_cycle;
    do_reset(1'b1);
    repeat (2) pulse(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    marker = 1'b1; step = 1'b1; step_up = 1'b1; step_on_b = 1'b1; step_rise = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk("R6 same cycle counts", W'(3));
    pulse(1'b1, 1'b1, 1'b1);
    chk("R6 later reload", W'(0));
  endtask

  task automatic t_rev;
    do_reset(1'b1);
    set_marker(1'b1, 1'b1);
    pulse(1'b1, 1'b1, 1'b1);
    chk("R4 first reload", W'(0));
    set_marker(1'b1, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3 reverse wrap", W'(9));
    set_marker(1'b0, 1'b1);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R5 rising not armed in reverse", W'(8));
    set_marker(1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b1);
    chk("R8 B rise ignored in reverse", W'(7));
    pulse(1'b0, 1'b1, 1'b0);
    chk("R5 R8 reverse reload on B fall", W'(9));
  endtask

  task automatic t_fd;
    do_reset(1'b1);
    fd_mode = 1'b1;
    repeat (3) pulse(1'b1, 1'b0, 1'b1);
    set_marker(1'b1, 1'b1);
    pulse(1'b1, 1'b1, 1'b1);
    chk("R9 fd no reload", W'(4));
    pulse(1'b1, 1'b0, 1'b1);
    chk("R9 fd still counting", W'(5));
  endtask

  task automatic t_disable;
    do_reset(1'b1);
    repeat (2) pulse(1'b1, 1'b0, 1'b1);
    set_marker(1'b1, 1'b1);
    pulse(1'b1, 1'b1, 1'b1);
    chk("R10 learn B rise", W'(0));
    @(negedge clk); zero_en = 1'b0;
    @(negedge clk); zero_en = 1'b1;
    pulse(1'b1, 1'b0, 1'b1);
    set_marker(1'b1, 1'b0);
    set_marker(1'b1, 1'b1);
    pulse(1'b1, 1'b0, 1'b1);
    chk("R10 relearned A rise", W'(0));
  endtask

  initial begin
    t_count;
    t_wrap;
    t_fwd;
    t_same_cycle;
    t_rev;
    t_fd;
    t_disable;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog count=%0d expected=done", count);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule